// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a bank of independent 32-bit down-counters placed behind an APB slave port. Each channel has a reload value, a live count, a small control word, a status bit, a clear-on-read acknowledge register and a dedicated interrupt line. A shared window at the top of the address map gives a combined view of every channel's pending state, a single register that acknowledges all channels at once, and a fixed identification word.

Software stops a channel, writes its reload value, and then sets the enable bit. One clock after enable rises, the count takes the reload value. After that it drops by one on every clock. When it steps past zero, the channel raises its pending flag and reloads. The reload value is either all-ones (free-running) or the programmed reload value (periodic). A per-channel mask keeps the interrupt line quiet, but the raw pending flag is still recorded. The number of channels is set at elaboration time. The whole block runs on the bus clock.

Top module: `apb_tmr_bank`

## Requirements
- R1: After reset, every reload value, count, control word and pending flag is zero and every interrupt line is low.
- R2: Every transfer completes in its access phase with no wait state: `pready` is 1 and `pslverr` is 0. A write takes effect at the clock edge that ends the access phase. Read data is valid during the access phase.
- R3: One clock after the enable bit (control bit 0) goes from 0 to 1, the count equals the reload value. On each following clock the count drops by one.
- R4: While enable is 0 the count holds its value.
- R5: With control bit 1 = 0 (free-running), a count of zero is followed by 0xFFFF_FFFF.
- R6: With control bit 1 = 1 (periodic), a count of zero is followed by the reload value.
- R7: Each step past zero sets the channel's raw pending flag, even if the channel is masked. Raw flags read back as bit n of offset 0xA8.
- R8: Control bit 2 is the mask (1 = masked). The channel status (channel offset +0x10, bit 0), bit n of offset 0xA0, and `irq_o[n]` all equal raw AND NOT mask.
- R9: Reading a channel's acknowledge register (channel offset +0x0C) clears only that channel's raw flag and returns zero.
- R10: Reading offset 0xA4 clears the raw flags of all channels.
- R11: Offset 0xAC returns the VERSION parameter. Writes to it and to other read-only registers are ignored. Unmapped or misaligned offsets read as zero.
- R12: With NUM_CH channels, the windows of absent channels are unmapped. Combined status bits at and above NUM_CH read as zero.
- R13: Channel n's window starts at n*0x14, with the reload value at +0x00, the count at +0x04 and control at +0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero outside a read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_o | output | NUM_CH | Per-channel interrupt, raw AND NOT mask |

## Verification
A write to a control or reload register becomes visible one clock after its access edge. A rising enable loads the count one clock after that, and each later clock removes one count. The bench therefore disables a channel exactly k+2 edges after the enable access and expects k+1 count steps from the reload value. Pending flags are read only after the channel is frozen, and the read side effect of an acknowledge is checked on a later read, never in the same access. Read data is sampled at the falling edge inside the access phase, while the registers are stable.

// File: rtl/apbtmr_pkg.sv
// Package: shared register map constants and the decoded-field type for the
// timer bank. Assumes word-aligned byte addresses on an 8-bit address bus.
package apbtmr_pkg;

    localparam int CH_STRIDE = 20;   // bytes per channel window
    localparam int MAX_CH    = 8;

    // offsets inside a channel window
    localparam int OFS_RELOAD = 0;
    localparam int OFS_COUNT  = 4;
    localparam int OFS_CTRL   = 8;
    localparam int OFS_ACK    = 12;
    localparam int OFS_STAT   = 16;

    // shared window
    localparam int ADR_ALL_STAT = 'hA0;
    localparam int ADR_ALL_ACK  = 'hA4;
    localparam int ADR_ALL_RAW  = 'hA8;
    localparam int ADR_IDENT    = 'hAC;

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_PER  = 1;
    localparam int CB_MASK = 2;

    typedef enum logic [3:0] {
        FLD_NONE,
        FLD_RELOAD,
        FLD_COUNT,
        FLD_CTRL,
        FLD_ACK,
        FLD_STAT,
        FLD_ALL_STAT,
        FLD_ALL_ACK,
        FLD_ALL_RAW,
        FLD_IDENT
    } fld_e;

endpackage

// File: rtl/tmr_addr_decode.sv
// Module: tmr_addr_decode
// Maps a byte address to a one-hot channel hit and a register field.
// Assumes NUM_CH*CH_STRIDE fits below the shared window; misaligned
// addresses and holes decode to FLD_NONE.
module tmr_addr_decode
    import apbtmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output fld_e              fld
);

    // Decode: per-channel window compare, then the shared block.
    always_comb begin
        ch_hit = '0;
        fld    = FLD_NONE;
        if (addr[1:0] == 2'b00) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr >= ADDR_W'(n * CH_STRIDE) &&
                    addr <  ADDR_W'(n * CH_STRIDE + CH_STRIDE)) begin
                    ch_hit[n] = 1'b1;
                    case (int'(addr - ADDR_W'(n * CH_STRIDE)))
                        OFS_RELOAD: fld = FLD_RELOAD;
                        OFS_COUNT:  fld = FLD_COUNT;
                        OFS_CTRL:   fld = FLD_CTRL;
                        OFS_ACK:    fld = FLD_ACK;
                        default:    fld = FLD_STAT;
                    endcase
                end
            end
            case (int'(addr))
                ADR_ALL_STAT: fld = FLD_ALL_STAT;
                ADR_ALL_ACK:  fld = FLD_ALL_ACK;
                ADR_ALL_RAW:  fld = FLD_ALL_RAW;
                ADR_IDENT:    fld = FLD_IDENT;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel
// One down-counter with reload register, control word and raw pending flag.
// Assumes the reload value is only changed while the channel is disabled;
// a wrap and a clear in the same cycle leave the flag set.
module tmr_channel
    import apbtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reload,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic [2:0]       ctrl_q,
    output logic             raw_q,
    output logic             wrap
);

    logic en_d;   // enable as seen one clock earlier

    // Wrap: an enabled, already-started counter stepping past zero.
    always_comb wrap = ctrl_q[CB_EN] && en_d && (count_q == '0);

    // Registers: bus writes, start load, count/reload, pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            raw_q    <= 1'b0;
            en_d     <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata;
            if (wr_ctrl)   ctrl_q   <= wdata[2:0];
            en_d <= ctrl_q[CB_EN];
            if (ctrl_q[CB_EN] && !en_d)
                count_q <= reload_q;
            else if (ctrl_q[CB_EN])
                count_q <= wrap ? (ctrl_q[CB_PER] ? reload_q : '1) : count_q - 1'b1;
            if (wrap)     raw_q <= 1'b1;
            else if (clr) raw_q <= 1'b0;
        end
    end

    a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_EN] && !en_d) |=> (count_q == $past(reload_q)));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_EN] && en_d && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CB_EN] |=> $stable(count_q));

    a_r5_free_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_EN] && en_d && count_q == '0 && !ctrl_q[CB_PER]) |=> (count_q == '1));

    a_r6_per_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_EN] && en_d && count_q == '0 && ctrl_q[CB_PER]) |=> (count_q == $past(reload_q)));

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> raw_q);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> !raw_q);

endmodule

// File: rtl/apb_tmr_bank.sv
// Module: apb_tmr_bank (top)
// APB slave over NUM_CH timer channels: decodes accesses, steers writes and
// clear-on-read acknowledges, muxes read data. Single clock, no wait states.
module apb_tmr_bank
    import apbtmr_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [7:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int ADDR_W = 8;

    logic [NUM_CH-1:0] ch_hit;
    fld_e              fld;
    logic              acc_wr, acc_rd, rd_all_ack;
    logic [31:0]       rdata;

    logic [CNT_W-1:0]  reload_a [NUM_CH];
    logic [CNT_W-1:0]  count_a  [NUM_CH];
    logic [2:0]        ctrl_a   [NUM_CH];
    logic [NUM_CH-1:0] raw_v, wrap_v, stat_v;

    tmr_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr   (paddr),
        .ch_hit (ch_hit),
        .fld    (fld)
    );

    // Access-phase strobes.
    always_comb begin
        acc_wr     = psel && penable && pwrite;
        acc_rd     = psel && penable && !pwrite;
        rd_all_ack = acc_rd && (fld == FLD_ALL_ACK);
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (pclk),
            .rst_n     (presetn),
            .wr_reload (acc_wr && ch_hit[n] && fld == FLD_RELOAD),
            .wr_ctrl   (acc_wr && ch_hit[n] && fld == FLD_CTRL),
            .wdata     (pwdata[CNT_W-1:0]),
            .clr       (rd_all_ack || (acc_rd && ch_hit[n] && fld == FLD_ACK)),
            .reload_q  (reload_a[n]),
            .count_q   (count_a[n]),
            .ctrl_q    (ctrl_a[n]),
            .raw_q     (raw_v[n]),
            .wrap      (wrap_v[n])
        );
        // Masked status per channel drives the interrupt line.
        always_comb stat_v[n] = raw_v[n] && !ctrl_a[n][CB_MASK];
    end

    always_comb irq_o = stat_v;

    // Read mux: channel fields, then shared fields; zero elsewhere.
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                case (fld)
                    FLD_RELOAD: rdata = 32'(reload_a[n]);
                    FLD_COUNT:  rdata = 32'(count_a[n]);
                    FLD_CTRL:   rdata = 32'(ctrl_a[n]);
                    FLD_STAT:   rdata = 32'(stat_v[n]);
                    default: ;
                endcase
            end
        end
        case (fld)
            FLD_ALL_STAT: rdata = 32'(stat_v);
            FLD_ALL_RAW:  rdata = 32'(raw_v);
            FLD_IDENT:    rdata = VERSION;
            default: ;
        endcase
    end

    // Bus outputs.
    always_comb begin
        prdata  = (psel && !pwrite) ? rdata : 32'd0;
        pready  = 1'b1;
        pslverr = 1'b0;
    end

    a_r10_all_clear: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_all_ack && wrap_v == '0) |=> (raw_v == '0));

    a_r8_irq_needs_raw: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(irq_o[0]) |-> raw_v[0]);

endmodule

// File: tb/tb_apb_tmr_bank.sv
module tb_apb_tmr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam logic [31:0] VER = 32'h0001_0200;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [NCH-1:0] irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    apb_tmr_bank #(.NUM_CH(NCH), .CNT_W(32), .VERSION(VER)) dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] reload;
        logic        per;
        logic        mask;
        logic [7:0]  k;
        logic [31:0] exp_count;
        logic        exp_raw;
    } vec_t;

    // k idle cycles while enabled => k+1 count steps after the start load
    localparam vec_t VECS [6] = '{
        '{2'd0, 32'd100, 1'b1, 1'b0, 8'd9, 32'd90,          1'b0},
        '{2'd1, 32'd3,   1'b1, 1'b0, 8'd4, 32'd2,           1'b1},
        '{2'd2, 32'd2,   1'b0, 1'b0, 8'd3, 32'hFFFF_FFFE,   1'b1},
        '{2'd0, 32'd0,   1'b1, 1'b0, 8'd1, 32'd0,           1'b1},
        '{2'd1, 32'd1,   1'b1, 1'b1, 8'd2, 32'd0,           1'b1},
        '{2'd2, 32'h10,  1'b0, 1'b0, 8'd0, 32'h0F,          1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge pclk); @(negedge pclk);
        penable = 1'b1;
        @(posedge pclk); @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge pclk); @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R2 pready", {31'd0, pready}, 32'd1);
        check("R2 pslverr", {31'd0, pslverr}, 32'd0);
        @(posedge pclk); @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [7:0] ch_adr(input int ch, input int ofs);
        return 8'(ch * 20 + ofs);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd, rd2;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        check("R1 irq", 32'(irq_o), 32'd0);
        for (int c = 0; c < NCH; c++) begin
            apb_rd(ch_adr(c, 0), rd);  check("R1 reload", rd, 0);
            apb_rd(ch_adr(c, 4), rd);  check("R1 count", rd, 0);
            apb_rd(ch_adr(c, 8), rd);  check("R1 ctrl", rd, 0);
        end
        apb_rd(8'hA8, rd); check("R1 raw", rd, 0);

        // Vector table: R3 R5 R6 R7 R8 R12 R13
        for (int v = 0; v < 6; v++) begin
            automatic int c = int'(VECS[v].ch);
            automatic logic [31:0] cw = {29'd0, VECS[v].mask, VECS[v].per, 1'b0};
            automatic logic st = VECS[v].exp_raw & ~VECS[v].mask;
            apb_wr(ch_adr(c, 8), cw);
            apb_wr(ch_adr(c, 0), VECS[v].reload);
            apb_rd(8'hA4, rd);
            apb_wr(ch_adr(c, 8), cw | 32'd1);
            repeat (int'(VECS[v].k)) @(negedge pclk);
            apb_wr(ch_adr(c, 8), cw);
            apb_rd(ch_adr(c, 4), rd);  check("R3/R5/R6 count", rd, VECS[v].exp_count);
            apb_rd(ch_adr(c, 8), rd);  check("R13 ctrl readback", rd, cw);
            apb_rd(8'hA8, rd);         check("R7/R12 raw", rd, 32'(VECS[v].exp_raw) << c);
            apb_rd(8'hA0, rd);         check("R8 all status", rd, 32'(st) << c);
            apb_rd(ch_adr(c, 16), rd); check("R8 channel status", rd, 32'(st));
            check("R8 irq", 32'(irq_o), 32'(st) << c);
        end

        // R3 count equals reload one clock after enable rises
        apb_wr(ch_adr(0, 8), 32'd0);
        apb_wr(ch_adr(0, 0), 32'd50);
        apb_wr(ch_adr(0, 8), 32'd3);
        apb_rd(ch_adr(0, 4), rd); check("R3 start load", rd, 32'd50);
        apb_wr(ch_adr(0, 8), 32'd2);

        // R4 hold while disabled
        apb_rd(ch_adr(0, 4), rd);
        repeat (20) @(negedge pclk);
        apb_rd(ch_adr(0, 4), rd2); check("R4 hold", rd2, rd);

        // R9 per-channel acknowledge, R10 global acknowledge
        apb_wr(ch_adr(0, 0), 32'd0);
        apb_wr(ch_adr(1, 0), 32'd0);
        apb_wr(ch_adr(0, 8), 32'd3);
        apb_wr(ch_adr(1, 8), 32'd3);
        repeat (3) @(negedge pclk);
        apb_wr(ch_adr(0, 8), 32'd2);
        apb_wr(ch_adr(1, 8), 32'd2);
        apb_rd(8'hA8, rd); check("R7 both pending", rd, 32'd3);
        apb_rd(ch_adr(0, 12), rd); check("R9 ack reads zero", rd, 32'd0);
        apb_rd(8'hA8, rd); check("R9 only ch0 cleared", rd, 32'd2);
        check("R9 irq", 32'(irq_o), 32'd2);
        apb_rd(8'hA4, rd);
        apb_rd(8'hA8, rd); check("R10 all cleared", rd, 32'd0);
        check("R10 irq", 32'(irq_o), 32'd0);

        // R11 identification, read-only writes, unmapped reads
        apb_rd(8'hAC, rd); check("R11 version", rd, VER);
        apb_wr(8'hAC, 32'hDEAD_BEEF);
        apb_rd(8'hAC, rd); check("R11 version write ignored", rd, VER);
        apb_wr(8'hA8, 32'hFFFF_FFFF);
        apb_rd(8'hA8, rd); check("R11 raw write ignored", rd, 32'd0);
        apb_rd(8'hB0, rd); check("R11 unmapped", rd, 32'd0);
        apb_rd(8'h02, rd); check("R11 misaligned", rd, 32'd0);

        // R12 absent channel window
        apb_wr(ch_adr(3, 0), 32'h1234_5678);
        apb_rd(ch_adr(3, 0), rd); check("R12 absent channel", rd, 32'd0);
        apb_rd(ch_adr(0, 0), rd); check("R12 ch0 untouched", rd, 32'd0);

        summary();
    end

endmodule